// File: doc/BRIEF.md
# FEAC codeword controller

This block carries far-end alarm and control codewords over an overhead channel that moves one bit per frame. The framer pulses `slotStb` once for each channel slot. On that pulse the transmit side hands over its current bit on `txBit`, and the receive side takes in the bit on `rxBit`. The same channel can be mapped onto a DS3 C-bit or onto the E3 national bit; that routing is left to the framer.

The transmit side takes one or two six-bit codes and one of three send modes. In single mode it sends one codeword. In repeat mode it sends the same codeword again and again until told to stop. In pair mode it sends two different codewords back to back, which is how line loopback commands are made. When nothing is being sent, the channel idles at all ones.

The receive side finds codewords in the incoming bit stream and checks that a code is stable before accepting it. Accepted codes go into a four-entry FIFO that a processor drains through a pop strobe.

Top module: `feac_ctrl`

## Requirements
- R1: After reset, `txBusy`, `rxNotEmpty` and `rxOverflow` are low, and `txBit` is 1. Whenever `txBusy` is low, `txBit` is 1.
- R2: A codeword for six-bit code d is 16 bits long. They go out in this order: a 0, then d[0] through d[5] (least significant first), then a 0, then eight 1s. Equivalently, the 16-bit word {8'hFF, 1'b0, d, 1'b0} is sent from bit 0 upward.
- R3: `txBit` changes only at a clock edge where `slotStb` is high (or where a send starts). Between slots it holds its value.
- R4: Mode 0 (single) sends `txCodeA` once. `txDone` is a one-cycle pulse after the last bit, and `txBusy` falls at the same time.
- R5: Mode 1 (repeat) sends `txCodeA` over and over. A `txStop` pulse lets the current codeword finish and then ends the send. This mode never raises `txDone`.
- R6: Mode 2 (pair) sends `txCodeA` and then `txCodeB` once, back to back, and then pulses `txDone`. Mode 3 behaves like mode 0.
- R7: `txStart` while `txBusy` is high is ignored: the codeword in flight and the mode in force do not change.
- R8: A received code is accepted after it is seen 8 times with at most 2 other codewords in between (8 of 10). A third mismatch restarts the count using the mismatching code. After a code is accepted, the count starts fresh.
- R9: Accepted codes are read from `rxCode` in arrival order. `rxNotEmpty` shows that the FIFO holds data, and `rxPop` removes the head entry. A pop on an empty FIFO has no effect.
- R10: The FIFO holds four codes. A code accepted while it is full is dropped and sets `rxOverflow`. `rxOverflow` stays set until the next pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotStb | input | 1 | One pulse per overhead channel slot |
| txStart | input | 1 | Starts a send when idle |
| txStop | input | 1 | Ends repeat mode at the next codeword boundary |
| txMode | input | 2 | 0 single, 1 repeat, 2 pair, 3 single |
| txCodeA | input | 6 | First (or only) code |
| txCodeB | input | 6 | Second code in pair mode |
| txBit | output | 1 | Outgoing channel bit for the current slot |
| txBusy | output | 1 | Send in progress |
| txDone | output | 1 | One-cycle pulse when a single or pair send ends |
| rxBit | input | 1 | Incoming channel bit, sampled on `slotStb` |
| rxPop | input | 1 | Removes the FIFO head entry |
| rxCode | output | 6 | Code at the FIFO head |
| rxNotEmpty | output | 1 | FIFO holds at least one code |
| rxOverflow | output | 1 | An accepted code was dropped because the FIFO was full |

## Verification
The bench builds the block with its default parameters: six-bit codes, an eight-bit flag of ones, an 8-of-10 acceptance rule and a four-entry FIFO. With these values a full codeword is only 16 slots long, so long repeat runs, pair sends and whole acceptance sequences fit in a short run. The small FIFO fills after four accepted codes, which lets the bench reach the overflow drop and the sticky flag. The tolerance of two mismatches is small enough that both a tolerated mix of codes and a forced restart can be checked directly.

// File: rtl/feac_pkg.sv
package feac_pkg;
  typedef enum logic [1:0] {
    MODE_ONCE   = 2'd0,
    MODE_REPEAT = 2'd1,
    MODE_PAIR   = 2'd2
  } feac_mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadA;
    logic loadB;
    logic txShift;
    logic rxShift;
    logic push;
  } feac_strb_t;
endpackage

// File: rtl/feac_ctrl_ctl.sv
module feac_ctrl_ctl import feac_pkg::*; #(
  parameter int CODE_W     = 6,
  parameter int ONES_W     = 8,
  parameter int MATCH_NEED = 8,
  parameter int MATCH_WIN  = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      slotStb,
  input  logic                      txStart,
  input  logic                      txStop,
  input  logic [1:0]                txMode,
  input  logic [CODE_W+ONES_W+1:0]  rxWin,
  output feac_strb_t                strb,
  output logic                      txBusy,
  output logic                      txDone,
  output logic [CODE_W-1:0]         acceptCode
);
  localparam int WORD_W   = CODE_W + ONES_W + 2;
  localparam int CNT_W    = $clog2(WORD_W);
  localparam int MISS_MAX = MATCH_WIN - MATCH_NEED;
  localparam int MC_W     = $clog2(MATCH_NEED + 1);
  localparam int MS_W     = $clog2(MISS_MAX + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
  localparam logic [MC_W-1:0]  NEED_M1  = MC_W'(MATCH_NEED - 1);
  localparam logic [MS_W-1:0]  MISS_TOP = MS_W'(MISS_MAX);

  typedef enum logic {TX_IDLE, TX_SEND} tx_state_e;

  // ---------------- transmit sequencer ----------------
  tx_state_e        state;
  logic [CNT_W-1:0] bitIdx;
  feac_mode_e       modeQ;
  logic             secondQ;
  logic             stopQ;
  logic             lastBit, boundary, startOk, finishing;

  assign txBusy   = (state == TX_SEND);
  assign lastBit  = (bitIdx == LAST_IDX);
  assign boundary = txBusy && slotStb && lastBit;
  assign startOk  = txStart && !txBusy;

  // ---------------- receive validation ----------------
  logic              rxFresh, detect, isMatch, restart;
  logic [CODE_W-1:0] rxCodeNow, cand;
  logic              candValid;
  logic [MC_W-1:0]   matchCnt;
  logic [MS_W-1:0]   missCnt;

  assign rxCodeNow = rxWin[CODE_W:1];
  assign detect    = rxFresh && (&rxWin[WORD_W-1:WORD_W-ONES_W])
                     && !rxWin[CODE_W+1] && !rxWin[0];
  assign isMatch   = candValid && (rxCodeNow == cand);
  assign restart   = candValid && !isMatch && (missCnt == MISS_TOP);
  assign acceptCode = cand;

  always_comb begin
    strb.loadA   = startOk ||
                   (boundary && modeQ == MODE_REPEAT && !(stopQ || txStop));
    strb.loadB   = boundary && modeQ == MODE_PAIR && !secondQ;
    strb.txShift = txBusy && slotStb && !lastBit;
    strb.rxShift = slotStb;
    strb.push    = detect && isMatch && (matchCnt == NEED_M1);
    finishing    = boundary && !strb.loadA && !strb.loadB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= TX_IDLE;
      bitIdx  <= '0;
      modeQ   <= MODE_ONCE;
      secondQ <= 1'b0;
      stopQ   <= 1'b0;
      txDone  <= 1'b0;
    end else begin
      txDone <= finishing && (modeQ != MODE_REPEAT);
      if (startOk) begin
        state   <= TX_SEND;
        bitIdx  <= '0;
        secondQ <= 1'b0;
        stopQ   <= 1'b0;
        case (txMode)
          2'd1:    modeQ <= MODE_REPEAT;
          2'd2:    modeQ <= MODE_PAIR;
          default: modeQ <= MODE_ONCE;
        endcase
      end else if (txBusy) begin
        if (txStop) stopQ <= 1'b1;
        if (slotStb) begin
          if (lastBit) begin
            bitIdx <= '0;
            if (strb.loadB) secondQ <= 1'b1;
            if (finishing)  state   <= TX_IDLE;
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxFresh   <= 1'b0;
      candValid <= 1'b0;
      cand      <= '0;
      matchCnt  <= '0;
      missCnt   <= '0;
    end else begin
      rxFresh <= slotStb;
      if (detect) begin
        if (!candValid || restart) begin
          candValid <= 1'b1;
          cand      <= rxCodeNow;
          matchCnt  <= MC_W'(1);
          missCnt   <= '0;
        end else if (isMatch) begin
          if (strb.push) candValid <= 1'b0;
          else           matchCnt  <= matchCnt + 1'b1;
        end else begin
          missCnt <= missCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/feac_ctrl_dp.sv
module feac_ctrl_dp import feac_pkg::*; #(
  parameter int CODE_W     = 6,
  parameter int ONES_W     = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  feac_strb_t                strb,
  input  logic                      txBusy,
  input  logic [CODE_W-1:0]         codeA,
  input  logic [CODE_W-1:0]         codeB,
  input  logic [CODE_W-1:0]         acceptCode,
  input  logic                      rxBit,
  input  logic                      rxPop,
  output logic                      txBit,
  output logic [CODE_W+ONES_W+1:0]  rxWin,
  output logic [CODE_W-1:0]         rxCode,
  output logic                      rxNotEmpty,
  output logic                      rxOverflow
);
  localparam int WORD_W = CODE_W + ONES_W + 2;
  localparam int PTR_W  = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam logic [PTR_W:0] FULL_CNT = (PTR_W+1)'(FIFO_DEPTH);

  function automatic logic [WORD_W-1:0] frameOf(input logic [CODE_W-1:0] c);
    return {{ONES_W{1'b1}}, 1'b0, c, 1'b0};
  endfunction

  logic [WORD_W-1:0] txSh;
  assign txBit = txBusy ? txSh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh  <= '1;
      rxWin <= '1;
    end else begin
      if (strb.loadA)        txSh <= frameOf(codeA);
      else if (strb.loadB)   txSh <= frameOf(codeB);
      else if (strb.txShift) txSh <= {1'b1, txSh[WORD_W-1:1]};
      if (strb.rxShift)      rxWin <= {rxBit, rxWin[WORD_W-1:1]};
    end
  end

  // ---------------- receive FIFO ----------------
  logic [CODE_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [PTR_W:0]    cnt;
  logic              full, doPop, doPush;

  assign full       = (cnt == FULL_CNT);
  assign rxNotEmpty = (cnt != '0);
  assign doPop      = rxPop && rxNotEmpty;
  assign doPush     = strb.push && (!full || doPop);
  assign rxCode     = mem[rdPtr];

  for (genvar g = 0; g < FIFO_DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN)                             mem[g] <= '0;
      else if (doPush && wrPtr == PTR_W'(g)) mem[g] <= acceptCode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      cnt        <= '0;
      rxOverflow <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(FIFO_DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(FIFO_DEPTH-1)) ? '0 : rdPtr + 1'b1;
      cnt <= cnt + (PTR_W+1)'(doPush) - (PTR_W+1)'(doPop);
      if (doPop)                     rxOverflow <= 1'b0;
      else if (strb.push && !doPush) rxOverflow <= 1'b1;
    end
  end
endmodule

// File: rtl/feac_ctrl.sv
module feac_ctrl import feac_pkg::*; #(
  parameter int CODE_W     = 6,
  parameter int ONES_W     = 8,
  parameter int MATCH_NEED = 8,
  parameter int MATCH_WIN  = 10,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slotStb,
  input  logic              txStart,
  input  logic              txStop,
  input  logic [1:0]        txMode,
  input  logic [CODE_W-1:0] txCodeA,
  input  logic [CODE_W-1:0] txCodeB,
  output logic              txBit,
  output logic              txBusy,
  output logic              txDone,
  input  logic              rxBit,
  input  logic              rxPop,
  output logic [CODE_W-1:0] rxCode,
  output logic              rxNotEmpty,
  output logic              rxOverflow
);
  localparam int WORD_W = CODE_W + ONES_W + 2;

  feac_strb_t        strb;
  logic [WORD_W-1:0] rxWin;
  logic [CODE_W-1:0] acceptCode;

  feac_ctrl_ctl #(
    .CODE_W(CODE_W), .ONES_W(ONES_W),
    .MATCH_NEED(MATCH_NEED), .MATCH_WIN(MATCH_WIN)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .slotStb(slotStb), .txStart(txStart),
    .txStop(txStop), .txMode(txMode), .rxWin(rxWin), .strb(strb),
    .txBusy(txBusy), .txDone(txDone), .acceptCode(acceptCode)
  );

  feac_ctrl_dp #(
    .CODE_W(CODE_W), .ONES_W(ONES_W), .FIFO_DEPTH(FIFO_DEPTH)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .txBusy(txBusy),
    .codeA(txCodeA), .codeB(txCodeB), .acceptCode(acceptCode),
    .rxBit(rxBit), .rxPop(rxPop), .txBit(txBit), .rxWin(rxWin),
    .rxCode(rxCode), .rxNotEmpty(rxNotEmpty), .rxOverflow(rxOverflow)
  );
endmodule

// File: rtl/feac_ctrl_chk.sv
module feac_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic slotStb,
  input logic txStart,
  input logic txBit,
  input logic txBusy,
  input logic txDone,
  input logic rxNotEmpty,
  input logic rxOverflow
);
  a_r1_idle_ones: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txBit);

  a_r3_bit_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && !slotStb && !txStart) |=> $stable(txBit));

  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txDone);

  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> !txBusy);

  a_r7_start_idle: assert property (@(posedge clk) disable iff (!rstN)
    (txStart && !txBusy) |=> txBusy);

  a_r10_ovf_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOverflow) |-> rxNotEmpty);
endmodule

bind feac_ctrl feac_ctrl_chk chk_i (.*);

// File: tb/feac_ctrl_tb_top.sv
`timescale 1ns/1ps
module feac_ctrl_tb_top;
  logic clk = 1'b0, rstN = 1'b0, slotStb = 1'b0, txStart = 1'b0, txStop = 1'b0;
  logic rxBit = 1'b1, rxPop = 1'b0;
  logic [1:0] txMode = 2'd0;
  logic [5:0] codeA = 6'd0, codeB = 6'd0;
  logic txBit, txBusy, txDone, rxNotEmpty, rxOverflow;
  logic [5:0] rxCode;
  int nChk = 0, nFail = 0, doneCnt = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  feac_ctrl dut_i (
    .clk(clk), .rstN(rstN), .slotStb(slotStb), .txStart(txStart),
    .txStop(txStop), .txMode(txMode), .txCodeA(codeA), .txCodeB(codeB),
    .txBit(txBit), .txBusy(txBusy), .txDone(txDone), .rxBit(rxBit),
    .rxPop(rxPop), .rxCode(rxCode), .rxNotEmpty(rxNotEmpty),
    .rxOverflow(rxOverflow)
  );

  function automatic logic [15:0] expWord(input logic [5:0] c);
    return {8'hFF, 1'b0, c, 1'b0};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    doneCnt = 0;
  endtask

  task automatic slot(input logic b, output logic t);
    @(negedge clk);
    slotStb = 1'b1; rxBit = b; t = txBit;
    @(negedge clk);
    slotStb = 1'b0; rxBit = 1'b1;
    if (txDone) doneCnt++;
    @(negedge clk);
  endtask

  task automatic startTx(input logic [1:0] m, input logic [5:0] a, input logic [5:0] b);
    @(negedge clk);
    txMode = m; codeA = a; codeB = b; txStart = 1'b1;
    @(negedge clk);
    txStart = 1'b0;
  endtask

  task automatic capWord(output logic [15:0] w);
    logic t;
    for (int i = 0; i < 16; i++) begin slot(1'b1, t); w[i] = t; end
  endtask

  task automatic sendRx(input logic [5:0] c);
    logic [15:0] w;
    logic t;
    w = expWord(c);
    for (int i = 0; i < 16; i++) slot(w[i], t);
  endtask

  task automatic popOne();
    @(negedge clk); rxPop = 1'b1;
    @(negedge clk); rxPop = 1'b0;
  endtask

  task automatic testReset();
    logic t;
    doReset();
    chk("R1 txBit after reset", int'(txBit), 1);
    chk("R1 txBusy after reset", int'(txBusy), 0);
    chk("R1 rxNotEmpty after reset", int'(rxNotEmpty), 0);
    chk("R1 rxOverflow after reset", int'(rxOverflow), 0);
    slot(1'b1, t);
    chk("R1 idle slot bit", int'(t), 1);
  endtask

  task automatic testSingle();
    logic [15:0] w;
    doReset();
    startTx(2'd0, 6'h2D, 6'h00);
    capWord(w);
    chk("R2 single word bits", int'(w), int'(expWord(6'h2D)));
    chk("R4 single done count", doneCnt, 1);
    chk("R4 single busy end", int'(txBusy), 0);
    chk("R1 idle after single", int'(txBit), 1);
  endtask

  task automatic testHold();
    logic t;
    doReset();
    startTx(2'd3, 6'h2D, 6'h00);
    repeat (5) @(negedge clk);
    chk("R3 first bit held", int'(txBit), 0);
    slot(1'b1, t);
    repeat (5) @(negedge clk);
    chk("R3 second bit held", int'(txBit), 1);
    for (int i = 1; i < 16; i++) slot(1'b1, t);
    chk("R6 mode 3 acts single", doneCnt, 1);
  endtask

  task automatic testRepeat();
    logic [15:0] w;
    logic t;
    doReset();
    startTx(2'd1, 6'h1A, 6'h00);
    for (int k = 0; k < 3; k++) begin
      capWord(w);
      chk("R5 repeat word", int'(w), int'(expWord(6'h1A)));
    end
    chk("R5 still busy", int'(txBusy), 1);
    for (int i = 0; i < 16; i++) begin
      if (i == 5) begin
        @(negedge clk); txStop = 1'b1;
        @(negedge clk); txStop = 1'b0;
      end
      slot(1'b1, t); w[i] = t;
    end
    chk("R5 final word complete", int'(w), int'(expWord(6'h1A)));
    chk("R5 stopped", int'(txBusy), 0);
    chk("R5 no done", doneCnt, 0);
  endtask

  task automatic testPair();
    logic [15:0] w;
    doReset();
    startTx(2'd2, 6'h09, 6'h36);
    capWord(w);
    chk("R6 pair first", int'(w), int'(expWord(6'h09)));
    chk("R6 no done mid pair", doneCnt, 0);
    capWord(w);
    chk("R6 pair second", int'(w), int'(expWord(6'h36)));
    chk("R6 pair done", doneCnt, 1);
    chk("R6 pair busy end", int'(txBusy), 0);
  endtask

  task automatic testBusyStart();
    logic [15:0] w;
    logic t;
    doReset();
    startTx(2'd0, 6'h15, 6'h00);
    for (int i = 0; i < 3; i++) begin slot(1'b1, t); w[i] = t; end
    startTx(2'd2, 6'h2A, 6'h2A);
    for (int i = 3; i < 16; i++) begin slot(1'b1, t); w[i] = t; end
    chk("R7 word unchanged", int'(w), int'(expWord(6'h15)));
    chk("R7 done once", doneCnt, 1);
    chk("R7 idle after", int'(txBusy), 0);
  endtask

  task automatic testRxValid();
    doReset();
    for (int i = 0; i < 7; i++) sendRx(6'h11);
    chk("R8 seven not enough", int'(rxNotEmpty), 0);
    sendRx(6'h11);
    chk("R8 eight accepted", int'(rxNotEmpty), 1);
    chk("R8 accepted code", int'(rxCode), 'h11);

    doReset();
    sendRx(6'h05); sendRx(6'h22); sendRx(6'h05); sendRx(6'h05); sendRx(6'h33);
    for (int i = 0; i < 4; i++) sendRx(6'h05);
    chk("R8 mixed seven", int'(rxNotEmpty), 0);
    sendRx(6'h05);
    chk("R8 mixed accepted", int'(rxNotEmpty), 1);
    chk("R8 mixed code", int'(rxCode), 'h05);

    doReset();
    sendRx(6'h01); sendRx(6'h02); sendRx(6'h03); sendRx(6'h3C);
    for (int i = 0; i < 6; i++) sendRx(6'h3C);
    chk("R8 restart not yet", int'(rxNotEmpty), 0);
    sendRx(6'h3C);
    chk("R8 restart accepted", int'(rxNotEmpty), 1);
    chk("R8 restart code", int'(rxCode), 'h3C);
  endtask

  task automatic testFifo();
    doReset();
    popOne();
    chk("R9 pop empty ignored", int'(rxNotEmpty), 0);
    chk("R9 pop empty no ovf", int'(rxOverflow), 0);
    for (int c = 1; c <= 4; c++)
      for (int i = 0; i < 8; i++) sendRx(6'(c));
    chk("R10 four fit", int'(rxOverflow), 0);
    for (int i = 0; i < 8; i++) sendRx(6'h05);
    chk("R10 overflow set", int'(rxOverflow), 1);
    for (int c = 1; c <= 4; c++) begin
      chk("R9 order", int'(rxCode), c);
      popOne();
      if (c == 1) chk("R10 ovf cleared by pop", int'(rxOverflow), 0);
    end
    chk("R10 newest dropped", int'(rxNotEmpty), 0);
  endtask

  initial begin
    testReset();
    testSingle();
    testHold();
    testRepeat();
    testPair();
    testBusyStart();
    testRxValid();
    testFifo();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChk++; nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule